// File: doc/BRIEF.md
# Lane Alignment Elastic Buffer

This block sits on the receive side of one lane of an 8b/10b serial link. The link controller moves the lane through four phases: an initial phase, comma synchronisation, the initial lane alignment sequence, and user data. During the alignment sequence the block watches for the lane alignment marker, which is a control character with value 0x7C. From that marker onward it writes every received character into a small circular store.

Until a start strobe arrives, the lane output stays at the idle comma. That comma is a control character with value 0xBC. The strobe is shared by all lanes. When it arrives, the block replays the stored characters in arrival order, beginning with the marker. A lane that saw its marker early therefore holds more characters in its store, and all lanes release the same character position together.

The frame size (octets per frame) and the multiframe size (frames per multiframe) are run-time inputs. Their product sets how many characters a lane may hold before the start strobe. Holding more than that counts as an alignment error.

Top module: `lane_align_buf`

## Requirements
- R1: The link state is 2 bits wide: 0 = initial, 1 = comma sync, 2 = alignment sequence, 3 = data. A character has four fields: a control flag, a disparity-error flag, a not-in-table flag, and an 8-bit value. In states 0 and 1, from the next cycle on, the output character is the comma (control=1, value 0xBC, both error flags 0), and ready, aligned and error are low.
- R2: In state 2, an input control character with value 0x7C raises ready one cycle later. Ready then stays high as long as the state is 2 or 3.
- R3: The value 0x7C does not raise ready when it arrives without the control flag. A control 0x7C does not raise ready when it arrives in state 3. In both cases the output stays at the comma.
- R4: While the lane is not aligned, the output is the comma and aligned is low, even when ready is high.
- R5: When start is sampled high while ready is high, aligned goes high one cycle later. In the same cycle the output carries the marker. After that the output carries one stored character per cycle, in arrival order, with all four fields kept.
- R6: Once aligned, the lane keeps replaying one character per cycle after start falls.
- R7: When start is sampled high while ready is low in state 2 or 3, error rises one cycle later and stays high. Aligned stays low.
- R8: The hold limit is frame size times multiframe size. When that product is 0 or larger than the store depth, the limit is the store depth instead. If a character arrives before alignment while the store already holds that many characters, error rises one cycle later and the character is dropped.
- R9: When the link state returns to 0 or 1, the next cycle clears ready, aligned, error and the store. A later marker starts a fresh alignment.
- R10: While the active-low reset is held low, the outputs are the comma with ready, aligned and error low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low reset |
| link_state | input | 2 | Link phase (0 initial, 1 comma sync, 2 alignment, 3 data) |
| start | input | 1 | Common release strobe |
| frame_octets | input | 9 | Octets per frame, 0 to 256 |
| frames_per_multi | input | 6 | Frames per multiframe, 0 to 32 |
| in_ctrl | input | 1 | Input control-character flag |
| in_disp_err | input | 1 | Input disparity-error flag |
| in_nit_err | input | 1 | Input not-in-table flag |
| in_data | input | 8 | Input character value |
| out_ctrl | output | 1 | Output control-character flag |
| out_disp_err | output | 1 | Output disparity-error flag |
| out_nit_err | output | 1 | Output not-in-table flag |
| out_data | output | 8 | Output character value |
| ready | output | 1 | Marker seen, capture running |
| aligned | output | 1 | Replay running |
| error | output | 1 | Early start or hold-limit overrun |

## Verification
Most faults in this block show up at the ports within a few cycles. A read pointer that is off by one shows on the first replayed character, in the cycle after start. That character is a data byte where the marker belongs. A write pointer that skips or repeats a cell corrupts a later replayed character. That happens exactly as many cycles after start as the lane's skew, so the sweep runs every skew from one character up to one past the hold limit. A wrong fill count, or a wrong limit computed from the frame parameters, moves the cycle in which error rises by one or more. It can also drop a character that should have been replayed. State that is not cleared on a return to comma sync shows up on the first cycle of the next run, as ready, aligned or error being high.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

  typedef enum logic [1:0] {
    LS_INIT = 2'd0,
    LS_SYNC = 2'd1,
    LS_ALGN = 2'd2,
    LS_DATA = 2'd3
  } link_st_t;

  typedef struct packed {
    logic       ctrl;
    logic       disp_err;
    logic       nit_err;
    logic [7:0] data;
  } lane_char_t;

  localparam int CHAR_W = $bits(lane_char_t);

  localparam logic [7:0] COMMA_BYTE  = 8'hBC;
  localparam logic [7:0] MARKER_BYTE = 8'h7C;

  localparam lane_char_t COMMA_CHAR = '{ctrl: 1'b1, disp_err: 1'b0,
                                        nit_err: 1'b0, data: COMMA_BYTE};

  // Characters a lane may hold before release: one multiframe, clipped to depth.
  function automatic int unsigned skew_limit(int unsigned octets,
                                             int unsigned frames,
                                             int unsigned depth);
    int unsigned span;
    span = octets * frames;
    if (span == 0 || span > depth) return depth;
    return span;
  endfunction

endpackage

// File: rtl/lane_align_store.sv
module lane_align_store #(
  parameter int DEPTH = 32,
  parameter int W     = 11,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (wr_en && waddr == AW'(g)) cells[g] <= wdata;
    end
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/lane_align_ctrl.sv
module lane_align_ctrl
  import lane_align_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    link_state,
  input  logic          start,
  input  logic          in_is_marker,
  input  logic [CW-1:0] limit,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic          ready,
  output logic          aligned,
  output logic          error
);

  link_st_t      st;
  logic          active;
  logic          arm;
  logic          early_start;
  logic          wr_req;
  logic          overrun;
  logic          ready_q, aligned_q, error_q;
  logic [CW-1:0] wptr, rptr, fill;

  assign st          = link_st_t'(link_state);
  assign active      = (st == LS_ALGN) || (st == LS_DATA);
  assign fill        = wptr - rptr;

  assign arm         = active && (st == LS_ALGN) && in_is_marker && !ready_q;
  assign early_start = active && start && !ready_q;
  assign rd_en       = active && ready_q && (aligned_q || start);
  assign wr_req      = active && (ready_q || arm);
  assign overrun     = wr_req && !rd_en && (fill == limit);
  assign wr_en       = wr_req && !overrun;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      ready_q   <= 1'b0;
      aligned_q <= 1'b0;
      error_q   <= 1'b0;
      wptr      <= '0;
      rptr      <= '0;
    end else begin
      ready_q   <= ready_q | arm;
      aligned_q <= aligned_q | rd_en;
      error_q   <= error_q | early_start | overrun;
      if (wr_en) wptr <= wptr + 1'b1;
      if (rd_en) rptr <= rptr + 1'b1;
    end
  end

  assign waddr   = wptr[AW-1:0];
  assign raddr   = rptr[AW-1:0];
  assign ready   = ready_q;
  assign aligned = aligned_q;
  assign error   = error_q;

  assert_idle_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!ready_q && !aligned_q && !error_q && fill == '0));

  assert_aligned_needs_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    aligned_q |-> ready_q);

  assert_fill_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  assert_early_start_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && start && !ready_q) |=> (error_q && !aligned_q));

  assert_ready_from_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_q) |-> $past(in_is_marker && st == LS_ALGN));

endmodule

// File: rtl/lane_align_buf.sv
module lane_align_buf
  import lane_align_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] link_state,
  input  logic       start,
  input  logic [8:0] frame_octets,
  input  logic [5:0] frames_per_multi,
  input  logic       in_ctrl,
  input  logic       in_disp_err,
  input  logic       in_nit_err,
  input  logic [7:0] in_data,
  output logic       out_ctrl,
  output logic       out_disp_err,
  output logic       out_nit_err,
  output logic [7:0] out_data,
  output logic       ready,
  output logic       aligned,
  output logic       error
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  lane_char_t    in_char, rd_char, out_q;
  logic          in_is_marker;
  logic [CW-1:0] limit;
  logic          wr_en, rd_en;
  logic [AW-1:0] waddr, raddr;

  assign in_char      = '{ctrl: in_ctrl, disp_err: in_disp_err,
                          nit_err: in_nit_err, data: in_data};
  assign in_is_marker = in_ctrl && (in_data == MARKER_BYTE);
  assign limit        = CW'(skew_limit(int'(frame_octets), int'(frames_per_multi), DEPTH));

  lane_align_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .link_state   (link_state),
    .start        (start),
    .in_is_marker (in_is_marker),
    .limit        (limit),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .waddr        (waddr),
    .raddr        (raddr),
    .ready        (ready),
    .aligned      (aligned),
    .error        (error)
  );

  lane_align_store #(.DEPTH(DEPTH), .W(CHAR_W)) u_store (
    .clk   (clk),
    .wr_en (wr_en),
    .waddr (waddr),
    .wdata (in_char),
    .raddr (raddr),
    .rdata (rd_char)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || !rd_en) out_q <= COMMA_CHAR;
    else                  out_q <= rd_char;
  end

  assign out_ctrl     = out_q.ctrl;
  assign out_disp_err = out_q.disp_err;
  assign out_nit_err  = out_q.nit_err;
  assign out_data     = out_q.data;

  assert_comma_until_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (out_q == COMMA_CHAR));

endmodule

// File: tb/lane_align_buf_test.sv
module lane_align_buf_test;

  localparam int DEPTH = 32;
  localparam logic [10:0] COMMA = {1'b1, 1'b0, 1'b0, 8'hBC};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] link_state = 2'd0;
  logic       start = 1'b0;
  logic [8:0] frame_octets = 9'd5;
  logic [5:0] frames_per_multi = 6'd4;
  logic       in_ctrl = 1'b0, in_disp_err = 1'b0, in_nit_err = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       out_ctrl, out_disp_err, out_nit_err;
  logic [7:0] out_data;
  logic       ready, aligned, error;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side expectation
  bit          m_rdy, m_al, m_err;
  logic [10:0] m_out;
  logic [10:0] q[$];
  int          lim;

  always #5 clk = ~clk;

  lane_align_buf #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .link_state(link_state), .start(start),
    .frame_octets(frame_octets), .frames_per_multi(frames_per_multi),
    .in_ctrl(in_ctrl), .in_disp_err(in_disp_err), .in_nit_err(in_nit_err),
    .in_data(in_data), .out_ctrl(out_ctrl), .out_disp_err(out_disp_err),
    .out_nit_err(out_nit_err), .out_data(out_data), .ready(ready),
    .aligned(aligned), .error(error)
  );

  function automatic int calc_lim(int f, int k);
    if (f * k == 0) return DEPTH;
    if (f * k > DEPTH) return DEPTH;
    return f * k;
  endfunction

  task automatic compare(input string tag);
    logic [10:0] got;
    got = {out_ctrl, out_disp_err, out_nit_err, out_data};
    checks++;
    if (got !== m_out || ready !== m_rdy || aligned !== m_al || error !== m_err) begin
      errors++;
      $display("FAIL %s: char=%h rdy=%b al=%b err=%b expected char=%h rdy=%b al=%b err=%b",
               tag, got, ready, aligned, error, m_out, m_rdy, m_al, m_err);
    end
  endtask

  task automatic clear_model();
    m_rdy = 0; m_al = 0; m_err = 0; m_out = COMMA; q.delete();
  endtask

  task automatic step(input logic [1:0] st, input logic s, input logic [10:0] ch,
                      input string tag);
    bit arm, early, rd, wreq, ovr;
    @(negedge clk);
    link_state = st; start = s;
    {in_ctrl, in_disp_err, in_nit_err, in_data} = ch;
    @(posedge clk);
    if (!st[1]) clear_model();
    else begin
      arm   = (st == 2'd2) && ch[10] && ch[7:0] == 8'h7C && !m_rdy;
      early = s && !m_rdy;
      rd    = m_rdy && (m_al || s);
      wreq  = m_rdy || arm;
      ovr   = wreq && !rd && (q.size() == lim);
      m_out = rd ? q.pop_front() : COMMA;
      if (wreq && !ovr) q.push_back(ch);
      m_err = m_err | early | ovr;
      m_al  = m_al | rd;
      m_rdy = m_rdy | arm;
    end
    #1 compare(tag);
  endtask

  task automatic set_cfg(input int f, input int k);
    frame_octets = 9'(f); frames_per_multi = 6'(k); lim = calc_lim(f, k);
  endtask

  task automatic idle_run();
    for (int i = 0; i < 2; i++) step(2'd0, 1'b0, 11'h000, "R1");
    for (int i = 0; i < 3; i++) step(2'd1, 1'b0, COMMA, "R1");
  endtask

  function automatic logic [10:0] pat(int i, int d);
    return {1'(i % 7 == 0), 1'(i % 3 == 0), 1'(i % 5 == 0), 8'(i * 13 + d * 5)};
  endfunction

  initial begin
    clear_model();
    lim = calc_lim(5, 4);
    repeat (2) @(posedge clk);
    #1 compare("R10");
    @(negedge clk) rst_n = 1'b1;

    // sweep every skew over several frame configurations
    for (int c = 0; c < 5; c++) begin
      case (c)
        0: set_cfg(5, 4);
        1: set_cfg(2, 2);
        2: set_cfg(3, 3);
        3: set_cfg(0, 7);
        default: set_cfg(8, 8);
      endcase
      for (int d = 1; d <= lim + 1; d++) begin
        idle_run();
        step(2'd2, 1'b0, {3'b100, 8'h7C}, "R2");
        for (int i = 1; i <= d + 12; i++) begin
          string tg;
          if (d > lim) tg = "R8";
          else if (i < d) tg = "R4";
          else if (i < d + 6) tg = "R5";
          else tg = "R6";
          step((i < 4) ? 2'd2 : 2'd3, (i >= d && i < d + 6), pat(i, d), tg);
        end
      end
    end

    // markers that must not arm capture
    set_cfg(5, 4);
    idle_run();
    step(2'd2, 1'b0, {3'b000, 8'h7C}, "R3");
    step(2'd3, 1'b0, {3'b100, 8'h7C}, "R3");
    step(2'd3, 1'b0, 11'h011, "R3");

    // start before any marker
    idle_run();
    step(2'd2, 1'b0, 11'h022, "R7");
    step(2'd2, 1'b1, 11'h023, "R7");
    step(2'd2, 1'b0, {3'b100, 8'h7C}, "R7");
    step(2'd3, 1'b1, 11'h024, "R7");
    step(2'd3, 1'b0, 11'h025, "R7");

    // drop back to comma sync mid-replay, then realign
    idle_run();
    step(2'd2, 1'b0, {3'b100, 8'h7C}, "R9");
    step(2'd2, 1'b0, 11'h031, "R9");
    step(2'd3, 1'b1, 11'h032, "R9");
    step(2'd3, 1'b1, 11'h033, "R9");
    step(2'd1, 1'b0, COMMA, "R9");
    step(2'd1, 1'b0, COMMA, "R9");
    step(2'd2, 1'b0, {3'b100, 8'h7C}, "R9");
    step(2'd2, 1'b0, 11'h041, "R9");
    step(2'd3, 1'b1, 11'h042, "R9");
    step(2'd3, 1'b0, 11'h043, "R9");
    step(2'd3, 1'b0, 11'h044, "R9");

    // reset during replay
    idle_run();
    step(2'd2, 1'b0, {3'b100, 8'h7C}, "R10");
    step(2'd3, 1'b1, 11'h051, "R10");
    @(negedge clk) rst_n = 1'b0;
    @(posedge clk);
    clear_model();
    #1 compare("R10");
    @(negedge clk) rst_n = 1'b1;
    step(2'd0, 1'b0, 11'h000, "R10");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule